// File: doc/BRIEF.md
# Multi-dimensional DMA descriptor request sequencer

This block walks a single DMA channel through buffer descriptors held in a small local table. A descriptor describes a buffer of up to four nested dimensions. The innermost dimension is a byte count that is consumed in chunks. Each outer dimension has its own repeat count and a signed address offset. Every accepted channel request turns into one bus transfer command that carries an address, a byte count and a priority. When that command is accepted, the sequencer advances the address and the per-dimension counters. When the outermost dimension finishes, it either chains to the next descriptor or returns to idle.

Two flow-control rules can be attached to the completion of any chosen dimension. The first freezes the channel until the host sends a release pulse. The second masks requests until the destination side reports that the last data has landed. Both request intake and command output use valid/ready handshakes. A request is taken only while `req_ready` is high. A command holds all of its fields steady until `cmd_ready` is seen, and back-pressure on the command side stops request intake, because only one command is ever outstanding. Control and status pins are plain levels or single-cycle pulses.

Top module: `md_dma_seq`

## Requirements
- R1: After a synchronous reset the channel is idle: `busy`, `frozen`, `masked`, `cmd_valid`, `req_ready`, `err_tsz` and `err_cfg` are 0, and `cur_idx` is 0.
- R2: Each command's length is the smaller of the bytes left in the current innermost pass and the size-code limit. Code 0 means 512 bytes, and codes 1 to 11 mean 2^(code-1) bytes (1 up to 1024).
- R3: Codes 12 to 15 are reserved. Loading such a descriptor sets `err_tsz`, leaves `busy` low, holds `req_ready` low, and no command is issued while requests are offered.
- R4: With the no-increment bit at 0 the address advances by each accepted command's length. With it at 1 the address stays unchanged between chunks.
- R5: When an innermost pass or an outer dimension finishes and the next dimension up still has repeats left, that dimension's signed 16-bit offset is added to the address. This happens whatever the no-increment bit says.
- R6: When the outermost dimension finishes and the continuous bit is set, the descriptor named by the 10-bit next index is loaded on the same accepting edge, and `cur_idx` shows that index. With the continuous bit clear the channel returns to idle (`busy` low).
- R7: A descriptor with size 0 sets `err_cfg`. So does a four-dimensional descriptor with the continuous bit set whose next index equals its own index. In both cases the channel stays out of service.
- R8: With freeze enabled, completing the selected dimension sets `frozen` and drops `req_ready`. A command already accepted still completes. Requests resume only after a `host_release` pulse.
- R9: With mask enabled, completing the selected dimension sets `masked` and drops `req_ready` until a `dst_done` pulse clears it.
- R10: Every command carries the descriptor's 2-bit priority on `cmd_prio`, where 0 is lowest and 3 is highest.
- R11: While `cmd_valid` is high and `cmd_ready` is low, the command fields stay stable. Address and counters change only on the edge where the command is accepted.
- R12: An accepted request yields `cmd_valid` on the next cycle. `req_ready` stays low while a command is pending, so each request produces exactly one command.
- R13: Descriptors are written through `tbl_wr_*`. The table index is the 10-bit index modulo the table depth (8 by default). A `go` pulse loads the descriptor at `go_idx`, clears `frozen` and `masked`, and starts the walk. Descriptor layout, MSB to LSB:
  - base address (32 bits)
  - size (16 bits)
  - dimension count minus one (2 bits)
  - repeat-minus-one counts for dimensions 3, 2, 1 (8 bits each)
  - signed offsets for dimensions 3, 2, 1 (16 bits each)
  - no-increment bit
  - continuous bit
  - next index (10 bits)
  - priority (2 bits)
  - size code (4 bits)
  - freeze enable, then freeze dimension (2 bits)
  - mask enable, then mask dimension (2 bits)

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tbl_wr_en | input | 1 | Descriptor table write strobe |
| tbl_wr_idx | input | 10 | Descriptor index to write |
| tbl_wr_data | input | 146 | Packed descriptor |
| go_i | input | 1 | Start pulse |
| go_idx | input | 10 | Descriptor to start from |
| req_valid | input | 1 | Channel request offered |
| req_ready | output | 1 | Channel request may be taken |
| cmd_valid | output | 1 | Transfer command valid |
| cmd_ready | input | 1 | Transfer command accepted |
| cmd_addr | output | 32 | Transfer address |
| cmd_len | output | 11 | Transfer byte count |
| cmd_prio | output | 2 | Transfer priority |
| dst_done | input | 1 | Destination reports last data landed |
| host_release | input | 1 | Host release of a frozen channel |
| busy | output | 1 | Channel is walking a descriptor |
| frozen | output | 1 | Channel frozen |
| masked | output | 1 | Requests masked |
| err_tsz | output | 1 | Reserved size code loaded |
| err_cfg | output | 1 | Illegal descriptor loaded |
| cur_idx | output | 10 | Index of the current descriptor |

## Verification
Each result has a fixed due time:
- `cmd_valid` and its fields appear one clock after the edge that accepts a request.
- Address, counters, `frozen`, `masked`, `cur_idx` and `busy` take their new values on the edge that accepts the command.
- The error flags settle one edge after `go_i`.
- `req_ready` follows the state combinationally.

The bench drives inputs and samples outputs only on falling edges. It lets exactly the edges above pass before each comparison, and it holds `cmd_ready` low for an extra cycle on every third command so the stability rule is sampled mid-stall. Expected addresses and lengths come from nested arithmetic loops over each descriptor's dimensions, swept over every legal size code.

// File: rtl/md_dma_pkg.sv
package md_dma_pkg;
  parameter int ADDR_W    = 32;
  parameter int SIZE_W    = 16;
  parameter int CNT_W     = 8;
  parameter int OFF_W     = 16;
  parameter int IDX_W     = 10;
  parameter int LEN_W     = 11;
  parameter int MAX_DIM   = 4;
  parameter int TSZ_W     = 4;
  parameter int PRIO_W    = 2;
  parameter int DIM_SEL_W = 2;
  parameter int TSZ_LAST  = 11;
  parameter int TSZ0_BYTES = 512;

  typedef struct packed {
    logic [ADDR_W-1:0]                  base;
    logic [SIZE_W-1:0]                  size;
    logic [DIM_SEL_W-1:0]               ndim_m1;
    logic [MAX_DIM-1:1][CNT_W-1:0]      reps;
    logic [MAX_DIM-1:1][OFF_W-1:0]      step_off;
    logic                               no_inc;
    logic                               cont;
    logic [IDX_W-1:0]                   next_idx;
    logic [PRIO_W-1:0]                  prio;
    logic [TSZ_W-1:0]                   tsz;
    logic                               frz_en;
    logic [DIM_SEL_W-1:0]               frz_dim;
    logic                               msk_en;
    logic [DIM_SEL_W-1:0]               msk_dim;
  } desc_t;

  localparam int DESC_W = $bits(desc_t);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_CMD, S_ERR} seq_st_e;

  function automatic logic tsz_reserved(input logic [TSZ_W-1:0] code);
    return code > TSZ_W'(TSZ_LAST);
  endfunction
endpackage

// File: rtl/md_desc_table.sv
module md_desc_table
  import md_dma_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  desc_t            wr_data,
  input  logic [IDX_W-1:0] rd_a_idx,
  output desc_t            rd_a,
  input  logic [IDX_W-1:0] rd_b_idx,
  output desc_t            rd_b
);
  desc_t mem [DEPTH];
  logic  unused_hi;

  assign unused_hi = ^{wr_idx[IDX_W-1:AW], rd_a_idx[IDX_W-1:AW], rd_b_idx[IDX_W-1:AW]};

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx[AW-1:0]] <= wr_data;
  end

  assign rd_a = mem[rd_a_idx[AW-1:0]];
  assign rd_b = mem[rd_b_idx[AW-1:0]];
endmodule

// File: rtl/md_chunk_calc.sv
module md_chunk_calc
  import md_dma_pkg::*;
(
  input  logic [TSZ_W-1:0]  tsz,
  input  logic [SIZE_W-1:0] rem,
  output logic [LEN_W-1:0]  len
);
  logic [LEN_W-1:0] limit;

  always_comb begin
    if (tsz == '0)
      limit = LEN_W'(TSZ0_BYTES);
    else if (tsz_reserved(tsz))
      limit = '0;
    else
      limit = LEN_W'(1) << (tsz - TSZ_W'(1));
    len = (rem < SIZE_W'(limit)) ? LEN_W'(rem) : limit;
  end
endmodule

// File: rtl/md_dim_step.sv
module md_dim_step
  import md_dma_pkg::*;
(
  input  logic [SIZE_W-1:0]              size,
  input  logic [DIM_SEL_W-1:0]           ndim_m1,
  input  logic [MAX_DIM-1:1][CNT_W-1:0]  reps,
  input  logic [MAX_DIM-1:1][OFF_W-1:0]  step_off,
  input  logic                           no_inc,
  input  logic [SIZE_W-1:0]              rem,
  input  logic [MAX_DIM-1:1][CNT_W-1:0]  cnt,
  input  logic [ADDR_W-1:0]              addr,
  input  logic [LEN_W-1:0]               len,
  output logic [SIZE_W-1:0]              rem_n,
  output logic [MAX_DIM-1:1][CNT_W-1:0]  cnt_n,
  output logic [ADDR_W-1:0]              addr_n,
  output logic [MAX_DIM-1:0]             fin,
  output logic                           last
);
  logic [SIZE_W-1:0]  rem_after;
  logic [MAX_DIM-1:1] step;
  logic [ADDR_W-1:0]  delta;

  assign rem_after = rem - SIZE_W'(len);
  assign fin[0]    = (rem_after == '0);

  for (genvar d = 1; d < MAX_DIM; d++) begin : g_dim
    logic act;
    assign act      = (DIM_SEL_W'(d) <= ndim_m1);
    assign fin[d]   = fin[d-1] & act & (cnt[d] == '0);
    assign step[d]  = fin[d-1] & act & (cnt[d] != '0);
    assign cnt_n[d] = fin[d]  ? reps[d] :
                      step[d] ? cnt[d] - CNT_W'(1) : cnt[d];
  end

  assign last  = fin[ndim_m1];
  assign rem_n = fin[0] ? size : rem_after;

  always_comb begin
    delta = no_inc ? '0 : ADDR_W'(len);
    for (int d = 1; d < MAX_DIM; d++) begin
      if (step[d])
        delta = delta + {{(ADDR_W-OFF_W){step_off[d][OFF_W-1]}}, step_off[d]};
    end
    addr_n = addr + delta;
  end
endmodule

// File: rtl/md_dma_seq.sv
module md_dma_seq
  import md_dma_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tbl_wr_en,
  input  logic [IDX_W-1:0]  tbl_wr_idx,
  input  logic [DESC_W-1:0] tbl_wr_data,
  input  logic              go_i,
  input  logic [IDX_W-1:0]  go_idx,
  input  logic              req_valid,
  output logic              req_ready,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [LEN_W-1:0]  cmd_len,
  output logic [PRIO_W-1:0] cmd_prio,
  input  logic              dst_done,
  input  logic              host_release,
  output logic              busy,
  output logic              frozen,
  output logic              masked,
  output logic              err_tsz,
  output logic              err_cfg,
  output logic [IDX_W-1:0]  cur_idx
);
  seq_st_e                        st_q;
  logic [IDX_W-1:0]               idx_q;
  logic [ADDR_W-1:0]              addr_q;
  logic [SIZE_W-1:0]              rem_q;
  logic [MAX_DIM-1:1][CNT_W-1:0]  cnt_q;
  logic [LEN_W-1:0]               len_q;
  logic                           frz_q, msk_q, etsz_q, ecfg_q;

  desc_t                          cur, ld;
  logic [IDX_W-1:0]               ld_idx;
  logic [LEN_W-1:0]               chunk_len;
  logic [SIZE_W-1:0]              rem_n;
  logic [MAX_DIM-1:1][CNT_W-1:0]  cnt_n;
  logic [ADDR_W-1:0]              addr_n;
  logic [MAX_DIM-1:0]             fin;
  logic                           last;
  logic                           req_fire, cmd_fire, load_now;
  logic                           ld_tsz_bad, ld_cfg_bad;
  logic                           frz_hit, msk_hit;
  logic                           unused_fields;

  assign ld_idx = go_i ? go_idx : cur.next_idx;

  md_desc_table #(.DEPTH(DEPTH)) u_tbl (
    .clk      (clk),
    .wr_en    (tbl_wr_en),
    .wr_idx   (tbl_wr_idx),
    .wr_data  (desc_t'(tbl_wr_data)),
    .rd_a_idx (idx_q),
    .rd_a     (cur),
    .rd_b_idx (ld_idx),
    .rd_b     (ld)
  );

  md_chunk_calc u_chunk (
    .tsz (cur.tsz),
    .rem (rem_q),
    .len (chunk_len)
  );

  md_dim_step u_step (
    .size     (cur.size),
    .ndim_m1  (cur.ndim_m1),
    .reps     (cur.reps),
    .step_off (cur.step_off),
    .no_inc   (cur.no_inc),
    .rem      (rem_q),
    .cnt      (cnt_q),
    .addr     (addr_q),
    .len      (len_q),
    .rem_n    (rem_n),
    .cnt_n    (cnt_n),
    .addr_n   (addr_n),
    .fin      (fin),
    .last     (last)
  );

  assign unused_fields = ^{cur.base, ld.step_off, ld.no_inc, ld.prio,
                           ld.frz_en, ld.frz_dim, ld.msk_en, ld.msk_dim};

  assign req_ready = (st_q == S_WAIT) && !frz_q && !msk_q;
  assign req_fire  = req_valid && req_ready;
  assign cmd_valid = (st_q == S_CMD);
  assign cmd_fire  = cmd_valid && cmd_ready;
  assign load_now  = go_i || (cmd_fire && last && cur.cont);

  assign ld_tsz_bad = tsz_reserved(ld.tsz);
  assign ld_cfg_bad = (ld.size == '0) ||
                      ((ld.ndim_m1 == DIM_SEL_W'(MAX_DIM-1)) && ld.cont && (ld.next_idx == ld_idx));

  assign frz_hit = cmd_fire && cur.frz_en && fin[cur.frz_dim];
  assign msk_hit = cmd_fire && cur.msk_en && fin[cur.msk_dim];

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= S_IDLE;
      idx_q  <= '0;
      addr_q <= '0;
      rem_q  <= '0;
      cnt_q  <= '0;
      len_q  <= '0;
      frz_q  <= 1'b0;
      msk_q  <= 1'b0;
      etsz_q <= 1'b0;
      ecfg_q <= 1'b0;
    end else begin
      if (host_release) frz_q <= 1'b0;
      if (dst_done)     msk_q <= 1'b0;
      if (frz_hit)      frz_q <= 1'b1;
      if (msk_hit)      msk_q <= 1'b1;

      case (st_q)
        S_WAIT: begin
          if (req_fire) begin
            len_q <= chunk_len;
            st_q  <= S_CMD;
          end
        end
        S_CMD: begin
          if (cmd_ready) begin
            rem_q  <= rem_n;
            cnt_q  <= cnt_n;
            addr_q <= addr_n;
            st_q   <= last ? S_IDLE : S_WAIT;
          end
        end
        default: ;
      endcase

      if (load_now) begin
        idx_q  <= ld_idx;
        addr_q <= ld.base;
        rem_q  <= ld.size;
        cnt_q  <= ld.reps;
        etsz_q <= ld_tsz_bad;
        ecfg_q <= ld_cfg_bad;
        st_q   <= (ld_tsz_bad || ld_cfg_bad) ? S_ERR : S_WAIT;
      end

      if (go_i) begin
        frz_q <= 1'b0;
        msk_q <= 1'b0;
      end
    end
  end

  assign cmd_addr = addr_q;
  assign cmd_len  = len_q;
  assign cmd_prio = cur.prio;
  assign busy     = (st_q == S_WAIT) || (st_q == S_CMD);
  assign frozen   = frz_q;
  assign masked   = msk_q;
  assign err_tsz  = etsz_q;
  assign err_cfg  = ecfg_q;
  assign cur_idx  = idx_q;
endmodule

// File: rtl/md_dma_seq_chk.sv
module md_dma_seq_chk
  import md_dma_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              tbl_wr_en,
  input logic              go_i,
  input logic              req_valid,
  input logic              req_ready,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic [LEN_W-1:0]  cmd_len,
  input logic [PRIO_W-1:0] cmd_prio,
  input logic              dst_done,
  input logic              busy,
  input logic              frozen,
  input logic              masked,
  input logic              err_tsz,
  input logic              err_cfg,
  input logic [IDX_W-1:0]  cur_idx
);
  logic rst_seen_q;

  always_ff @(posedge clk) rst_seen_q <= rst;

  always_ff @(posedge clk) begin
    if (rst_seen_q && !rst) begin
      a_r1_reset_state: assert (!busy && !frozen && !masked && !cmd_valid && !req_ready &&
                                !err_tsz && !err_cfg && cur_idx == '0)
        else $error("R1 state after reset");
    end
  end

  a_r11_cmd_hold: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !cmd_ready && !go_i && !tbl_wr_en) |=>
      (cmd_valid && $stable(cmd_addr) && $stable(cmd_len) && $stable(cmd_prio)));

  a_r12_req_to_cmd: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && !go_i) |=> cmd_valid);

  a_r12_single_pending: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> !req_ready);

  a_r8_frozen_blocks: assert property (@(posedge clk) disable iff (rst)
    frozen |-> !req_ready);

  a_r8_freeze_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(frozen) |-> $past(cmd_valid && cmd_ready));

  a_r9_masked_blocks: assert property (@(posedge clk) disable iff (rst)
    masked |-> !req_ready);

  a_r9_unmask_cause: assert property (@(posedge clk) disable iff (rst)
    $fell(masked) |-> $past(dst_done || go_i));

  a_r2_len_range: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> (cmd_len != '0 && cmd_len <= LEN_W'(1024)));

  a_r3_no_cmd_on_err: assert property (@(posedge clk) disable iff (rst)
    (err_tsz || err_cfg) |-> (!cmd_valid && !busy));
endmodule

bind md_dma_seq md_dma_seq_chk chk_i (.*);

// File: tb/md_dma_seq_tb_top.sv
module md_dma_seq_tb_top;
  import md_dma_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              tbl_wr_en = 1'b0;
  logic [IDX_W-1:0]  tbl_wr_idx = '0;
  logic [DESC_W-1:0] tbl_wr_data = '0;
  logic              go_i = 1'b0;
  logic [IDX_W-1:0]  go_idx = '0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic              cmd_valid;
  logic              cmd_ready = 1'b0;
  logic [ADDR_W-1:0] cmd_addr;
  logic [LEN_W-1:0]  cmd_len;
  logic [PRIO_W-1:0] cmd_prio;
  logic              dst_done = 1'b0;
  logic              host_release = 1'b0;
  logic              busy, frozen, masked, err_tsz, err_cfg;
  logic [IDX_W-1:0]  cur_idx;

  int n_chk = 0;
  int n_bad = 0;
  int n_cyc = 0;
  int n_iss = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  md_dma_seq dut_i (
    .clk, .rst, .tbl_wr_en, .tbl_wr_idx, .tbl_wr_data, .go_i, .go_idx,
    .req_valid, .req_ready, .cmd_valid, .cmd_ready, .cmd_addr, .cmd_len, .cmd_prio,
    .dst_done, .host_release, .busy, .frozen, .masked, .err_tsz, .err_cfg, .cur_idx
  );

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  always @(posedge clk) begin
    n_cyc++;
    if (n_cyc > WATCHDOG) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog (all R) cycles %0d expected below %0d", n_cyc, WATCHDOG);
      summary();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic eq(input string req, input string what, input longint act, input longint exp);
    chk(act == exp, req, what, act, exp);
  endtask

  function automatic desc_t blank();
    desc_t d;
    d = '0;
    d.tsz = 4'd3;
    d.size = 16'd4;
    return d;
  endfunction

  function automatic int lim_of(input logic [3:0] c);
    if (c == 4'd0) return 512;
    return 1 << (int'(c) - 1);
  endfunction

  function automatic longint sx(input logic [15:0] v);
    return longint'($signed(v));
  endfunction

  task automatic wr(input int idx, input desc_t d);
    @(negedge clk);
    tbl_wr_en = 1'b1;
    tbl_wr_idx = IDX_W'(idx);
    tbl_wr_data = d;
    @(negedge clk);
    tbl_wr_en = 1'b0;
  endtask

  task automatic go(input int idx);
    @(negedge clk);
    go_i = 1'b1;
    go_idx = IDX_W'(idx);
    @(negedge clk);
    go_i = 1'b0;
  endtask

  task automatic issue(input logic [31:0] ea, input int el, input logic [1:0] ep, input string atag);
    logic [31:0] a0;
    int w;
    w = 0;
    req_valid = 1'b1;
    while (!req_ready && w < 50) begin
      @(negedge clk);
      w++;
    end
    chk(req_ready, "R12", "req_ready before request", longint'(req_ready), 1);
    @(negedge clk);
    req_valid = 1'b0;
    eq("R12", "cmd_valid after request", longint'(cmd_valid), 1);
    eq("R12", "req_ready while pending", longint'(req_ready), 0);
    eq("R2", "cmd_len", longint'(cmd_len), longint'(el));
    eq(atag, "cmd_addr", longint'(cmd_addr), longint'(ea));
    eq("R10", "cmd_prio", longint'(cmd_prio), longint'(ep));
    a0 = cmd_addr;
    if (n_iss % 3 == 1) begin
      @(negedge clk);
      eq("R11", "cmd_valid during stall", longint'(cmd_valid), 1);
      eq("R11", "cmd_addr during stall", longint'(cmd_addr), longint'(a0));
      eq("R11", "cmd_len during stall", longint'(cmd_len), longint'(el));
    end
    n_iss++;
    cmd_ready = 1'b1;
    @(negedge clk);
    cmd_ready = 1'b0;
  endtask

  task automatic freeze_check();
    eq("R8", "frozen after dimension end", longint'(frozen), 1);
    eq("R8", "req_ready while frozen", longint'(req_ready), 0);
    req_valid = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      eq("R8", "cmd_valid while frozen", longint'(cmd_valid), 0);
    end
    req_valid = 1'b0;
    host_release = 1'b1;
    @(negedge clk);
    host_release = 1'b0;
    eq("R8", "frozen after release", longint'(frozen), 0);
  endtask

  task automatic mask_check();
    eq("R9", "masked after dimension end", longint'(masked), 1);
    eq("R9", "req_ready while masked", longint'(req_ready), 0);
    req_valid = 1'b1;
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      eq("R9", "cmd_valid while masked", longint'(cmd_valid), 0);
    end
    req_valid = 1'b0;
    dst_done = 1'b1;
    @(negedge clk);
    dst_done = 1'b0;
    eq("R9", "masked after destination done", longint'(masked), 0);
  endtask

  task automatic serve(input desc_t d, input string atag);
    int nd, c1, c2, c3, lim, rem, ln;
    longint a;
    bit [3:0] f;
    nd  = int'(d.ndim_m1) + 1;
    c1  = (nd >= 2) ? int'(d.reps[1]) : 0;
    c2  = (nd >= 3) ? int'(d.reps[2]) : 0;
    c3  = (nd >= 4) ? int'(d.reps[3]) : 0;
    lim = lim_of(d.tsz);
    a   = longint'(d.base);
    for (int i3 = 0; i3 <= c3; i3++) begin
      for (int i2 = 0; i2 <= c2; i2++) begin
        for (int i1 = 0; i1 <= c1; i1++) begin
          rem = int'(d.size);
          while (rem > 0) begin
            ln = (rem < lim) ? rem : lim;
            issue(32'(a), ln, d.prio, atag);
            if (!d.no_inc) a += ln;
            rem -= ln;
            if (rem == 0) begin
              f[0] = 1'b1;
              f[1] = (nd >= 2) && (i1 == c1);
              f[2] = f[1] && (nd >= 3) && (i2 == c2);
              f[3] = f[2] && (nd >= 4) && (i3 == c3);
              if (nd >= 2 && i1 < c1)              a += sx(d.step_off[1]);
              else if (f[1] && nd >= 3 && i2 < c2) a += sx(d.step_off[2]);
              else if (f[2] && nd >= 4 && i3 < c3) a += sx(d.step_off[3]);
              if (d.frz_en && f[d.frz_dim]) freeze_check();
              if (d.msk_en && f[d.msk_dim]) mask_check();
            end
          end
        end
      end
    end
    if (d.cont) begin
      eq("R6", "cur_idx after chain", longint'(cur_idx), longint'(d.next_idx));
      eq("R6", "busy after chain", longint'(busy), 1);
    end else begin
      eq("R6", "busy after last transfer", longint'(busy), 0);
    end
  endtask

  initial begin
    desc_t d, e;
    int sizes [3] = '{1, 5, 700};

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    eq("R1", "busy", longint'(busy), 0);
    eq("R1", "frozen", longint'(frozen), 0);
    eq("R1", "masked", longint'(masked), 0);
    eq("R1", "cmd_valid", longint'(cmd_valid), 0);
    eq("R1", "req_ready", longint'(req_ready), 0);
    eq("R1", "err flags", longint'({err_tsz, err_cfg}), 0);
    eq("R1", "cur_idx", longint'(cur_idx), 0);

    // R2 R4 R10: sweep of every legal size code, three sizes, both increment modes
    for (int c = 0; c <= 11; c++) begin
      for (int s = 0; s < 3; s++) begin
        for (int ni = 0; ni < 2; ni++) begin
          d = blank();
          d.base = 32'h1000 + 32'(c * 16 + s * 4096);
          d.size = 16'(sizes[s]);
          d.tsz = 4'(c);
          d.no_inc = ni[0];
          d.prio = 2'(c);
          wr(2, d);
          go(2);
          eq("R13", "busy after go", longint'(busy), 1);
          eq("R13", "cur_idx after go", longint'(cur_idx), 2);
          serve(d, "R4");
        end
      end
    end

    // R3: reserved size codes
    for (int c = 12; c <= 15; c++) begin
      d = blank();
      d.tsz = 4'(c);
      wr(3, d);
      go(3);
      eq("R3", "err_tsz", longint'(err_tsz), 1);
      eq("R3", "busy", longint'(busy), 0);
      eq("R3", "req_ready", longint'(req_ready), 0);
      req_valid = 1'b1;
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        eq("R3", "cmd_valid with reserved code", longint'(cmd_valid), 0);
      end
      req_valid = 1'b0;
    end

    // R5: offsets with increment off, then 3-D with increment on
    d = blank();
    d.base = 32'h8000; d.size = 16'd6; d.tsz = 4'd3; d.no_inc = 1'b1;
    d.ndim_m1 = 2'd1; d.reps[1] = 8'd2; d.step_off[1] = 16'(-100); d.prio = 2'd2;
    wr(4, d); go(4); serve(d, "R5");
    d = blank();
    d.base = 32'h2000; d.size = 16'd5; d.tsz = 4'd2;
    d.ndim_m1 = 2'd2; d.reps[1] = 8'd1; d.reps[2] = 8'd2;
    d.step_off[1] = 16'h0040; d.step_off[2] = 16'(-512); d.prio = 2'd3;
    wr(4, d); go(4); serve(d, "R5");

    // R8: freeze on the innermost dimension
    d = blank();
    d.base = 32'h200; d.size = 16'd4; d.tsz = 4'd3;
    d.ndim_m1 = 2'd1; d.reps[1] = 8'd2; d.step_off[1] = 16'd8;
    d.frz_en = 1'b1; d.frz_dim = 2'd0;
    wr(7, d); go(7); serve(d, "R5");

    // R9: mask on dimension 1 of a 3-D buffer
    d = blank();
    d.base = 32'h300; d.size = 16'd3; d.tsz = 4'd2;
    d.ndim_m1 = 2'd2; d.reps[1] = 8'd1; d.reps[2] = 8'd1;
    d.step_off[1] = 16'(-4); d.step_off[2] = 16'd32;
    d.msk_en = 1'b1; d.msk_dim = 2'd1;
    wr(7, d); go(7); serve(d, "R5");

    // R6: chain from one descriptor to another, then idle
    d = blank();
    d.base = 32'h5000; d.size = 16'd10; d.tsz = 4'd3; d.cont = 1'b1; d.next_idx = 10'd4; d.prio = 2'd1;
    e = blank();
    e.base = 32'h6000; e.size = 16'd3; e.tsz = 4'd1; e.no_inc = 1'b1; e.prio = 2'd3;
    wr(3, d); wr(4, e); go(3);
    serve(d, "R4");
    serve(e, "R4");

    // R7: size zero and four-dimensional self chain
    d = blank();
    d.size = 16'd0;
    wr(5, d); go(5);
    eq("R7", "err_cfg on zero size", longint'(err_cfg), 1);
    eq("R7", "busy on zero size", longint'(busy), 0);
    d = blank();
    d.ndim_m1 = 2'd3; d.cont = 1'b1; d.next_idx = 10'd5;
    wr(5, d); go(5);
    eq("R7", "err_cfg on self chain", longint'(err_cfg), 1);
    eq("R7", "req_ready on self chain", longint'(req_ready), 0);

    // R5 R6 R7: legal 4-D chained buffer into a no-increment descriptor
    d = blank();
    d.base = 32'h4000; d.size = 16'd2; d.tsz = 4'd2; d.ndim_m1 = 2'd3;
    d.reps[1] = 8'd1; d.reps[2] = 8'd1; d.reps[3] = 8'd1;
    d.step_off[1] = 16'h0010; d.step_off[2] = 16'h0100; d.step_off[3] = 16'h1000;
    d.cont = 1'b1; d.next_idx = 10'd6;
    e = blank();
    e.base = 32'h9000; e.size = 16'd3; e.tsz = 4'd1; e.no_inc = 1'b1;
    wr(5, d); wr(6, e); go(5);
    eq("R7", "err_cfg on legal 4-D", longint'(err_cfg), 0);
    serve(d, "R5");
    serve(e, "R4");

    // R13: index taken modulo the table depth
    d = blank();
    d.base = 32'hA000; d.size = 16'd9; d.tsz = 4'd3; d.prio = 2'd2;
    wr(9, d); go(1);
    eq("R13", "cur_idx for aliased entry", longint'(cur_idx), 1);
    serve(d, "R13");
    go(9);
    eq("R13", "cur_idx for wide index", longint'(cur_idx), 9);
    serve(d, "R13");

    summary();
    $finish;
  end
endmodule